// File: doc/BRIEF.md
# Floating-Point Status and Exception Capture

This block is the control and status register of a floating-point unit. Software loads it with a plain write. Only the implemented bits are kept. The stored rounding-mode field and the denormal control bit drive two mode outputs that the arithmetic datapath uses.

The block does not compute anything itself. When an arithmetic operation finishes, the datapath pulses a completion strobe and presents that operation's five raw exception bits. It can also raise a hint that the operation was an approximate reciprocal square root. On each completion the block replaces the cause field with the operation's exceptions and adds them to the sticky flags. If any new cause is enabled, the block raises a one-cycle trap that carries a fixed vector code.

Top module: `fpsr_unit`

## Requirements
- R1: A write stores `wrData & 32'h0005_FFFF` into the register, visible on `csrOut` in the cycle after the write. Bits 17 and 19 to 31 always read 0. The fields are: rounding mode in bits 1:0, sticky flags in bits 6:2, enables in bits 11:7, cause in bits 16:12, and denormal control in bit 18.
- R2: `roundToZero` is 1 exactly when the rounding field (bits 1:0) holds 2'b01. The encodings 00, 10 and 11 give 0, which selects round-to-nearest-even.
- R3: `flushDenorm` follows bit 18 of the register.
- R4: Each accepted completion overwrites the cause field with that operation's exception vector. Earlier cause bits do not survive. In every 5-bit field and in `opExc`, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid.
- R5: Each accepted completion ORs its exception vector into the flag field. Flags only accumulate, and only a software write clears them.
- R6: A completion with no exceptions leaves cause at zero, keeps the flags unchanged and raises no trap.
- R7: If the new cause ANDed with the enables is nonzero, `trapPulse` is high for exactly the one cycle after the strobe, with `trapCode` = 12'h120. At all other times `trapPulse` is 0 and `trapCode` is 0.
- R8: When `opApprox` is set and `opExc` is zero, the block records inexact (5'b00001). When `opApprox` is set and `opExc` is nonzero, the block records `opExc` unchanged, without adding inexact.
- R9: A write in the same cycle as a completion strobe wins. That completion is discarded and raises no trap.
- R10: After reset the register is zero, `roundToZero`, `flushDenorm` and `trapPulse` are 0, and `trapCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Software write value |
| opDone | input | 1 | Operation-complete strobe |
| opExc | input | 5 | Raw exception vector of the completed operation |
| opApprox | input | 1 | Completed operation was an approximate reciprocal square root |
| csrOut | output | 32 | Current register contents |
| roundToZero | output | 1 | Truncating rounding selected |
| flushDenorm | output | 1 | Flush denormals to zero |
| trapPulse | output | 1 | Floating-point trap request, one cycle |
| trapCode | output | 12 | Trap vector code, 12'h120 while trapping |

## Verification
The bench runs two operations in a row with different exceptions. A design that ORs into cause instead of rebuilding it would show stale cause bits, and one that rebuilds flags would lose earlier ones. It runs the approximate hint both with and without other exceptions. A wrong design would either miss the forced inexact or add inexact on top of a real fault. It also sends a write and a completion in the same cycle, and checks the idle cycle that follows a trap. Getting these wrong would show up as corrupted fields, a spurious trap, or a trap that stays high for more than one cycle.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int CSR_W       = 32;
  localparam int EXC_W       = 5;
  localparam int RM_W        = 2;
  localparam int RM_LO       = 0;
  localparam int FLAG_LO     = 2;
  localparam int EN_LO       = FLAG_LO + EXC_W;
  localparam int CAUSE_LO    = EN_LO + EXC_W;
  localparam int DN_BIT      = 18;
  localparam int CODE_W      = 12;
  localparam logic [RM_W-1:0]   RM_TRUNC  = 2'b01;
  localparam logic [CSR_W-1:0]  CSR_MASK  = 32'h0005_FFFF;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;
  localparam logic [EXC_W-1:0]  EXC_INEXACT = 5'b00001;

  typedef struct packed {
    logic             load;
    logic             update;
    logic [EXC_W-1:0] exc;
  } ctl_t;
endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             opDone,
  input  logic [EXC_W-1:0] opExc,
  input  logic             opApprox,
  output ctl_t             ctl
);
  logic forceInexact;

  always_comb begin
    forceInexact = opApprox && (opExc == '0);
    ctl.load     = wrEn;
    ctl.update   = opDone && !wrEn;
    ctl.exc      = forceInexact ? EXC_INEXACT : opExc;
  end

  // R8: a real exception is passed on untouched, approximate or not
  p_keep_real_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.update && opExc != '0) |-> (ctl.exc == opExc));

  // R9: a write never coexists with an accepted completion
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !ctl.update);
endmodule

// File: rtl/fpsr_data.sv
module fpsr_data
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [CSR_W-1:0]  wrData,
  output logic [CSR_W-1:0]  csrQ,
  output logic              trapQ,
  output logic [CODE_W-1:0] codeQ
);
  logic [CSR_W-1:0] csrD;
  logic             trapD;
  logic [EXC_W-1:0] enables, flags, cause;

  assign enables = csrQ[EN_LO +: EXC_W];
  assign flags   = csrQ[FLAG_LO +: EXC_W];
  assign cause   = csrQ[CAUSE_LO +: EXC_W];

  always_comb begin
    csrD  = csrQ;
    trapD = 1'b0;
    if (ctl.load) begin
      csrD = wrData & CSR_MASK;
    end else if (ctl.update) begin
      csrD[CAUSE_LO +: EXC_W] = ctl.exc;
      csrD[FLAG_LO +: EXC_W]  = flags | ctl.exc;
      trapD                   = |(ctl.exc & enables);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrQ  <= '0;
      trapQ <= 1'b0;
      codeQ <= '0;
    end else begin
      csrQ  <= csrD;
      trapQ <= trapD;
      codeQ <= trapD ? TRAP_CODE : '0;
    end
  end

  // R1: a write lands masked one cycle later
  p_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (csrQ == ($past(wrData) & CSR_MASK)));

  // R5: flags never lose a bit across a completion
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.update |=> ((flags & $past(flags)) == $past(flags)));

  // R6: a clean completion clears cause, keeps flags, no trap
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.update && ctl.exc == '0) |=> (cause == '0 && $stable(flags) && !trapQ));

  // R7: a trap implies an enabled cause and carries the vector code
  p_trap_r7: assert property (@(posedge clk) disable iff (!rstN)
    trapQ |-> ((cause & enables) != '0 && codeQ == TRAP_CODE));
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CSR_W-1:0]  wrData,
  input  logic              opDone,
  input  logic [EXC_W-1:0]  opExc,
  input  logic              opApprox,
  output logic [CSR_W-1:0]  csrOut,
  output logic              roundToZero,
  output logic              flushDenorm,
  output logic              trapPulse,
  output logic [CODE_W-1:0] trapCode
);
  ctl_t ctl;

  fpsr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opDone(opDone),
    .opExc(opExc), .opApprox(opApprox), .ctl(ctl)
  );

  fpsr_data uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .csrQ(csrOut), .trapQ(trapPulse), .codeQ(trapCode)
  );

  assign roundToZero = (csrOut[RM_LO +: RM_W] == RM_TRUNC);
  assign flushDenorm = csrOut[DN_BIT];
endmodule

// File: tb/tb_fpsr_unit.sv
`timescale 1ns/1ps
module tb_fpsr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        opDone = 1'b0;
  logic [4:0]  opExc = '0;
  logic        opApprox = 1'b0;
  logic [31:0] csrOut;
  logic        roundToZero, flushDenorm, trapPulse;
  logic [11:0] trapCode;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] csr;
    logic        rtz;
    logic        fz;
    logic        trap;
    logic [11:0] code;
    string       req;
  } item_t;
  item_t expQ[$];
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  fpsr_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .opDone(opDone),
    .opExc(opExc), .opApprox(opApprox), .csrOut(csrOut), .roundToZero(roundToZero),
    .flushDenorm(flushDenorm), .trapPulse(trapPulse), .trapCode(trapCode)
  );

  function automatic void pushExp(logic t, string req);
    item_t it;
    it.csr  = model;
    it.rtz  = (model[1:0] == 2'b01);
    it.fz   = model[18];
    it.trap = t;
    it.code = t ? 12'h120 : 12'h000;
    it.req  = req;
    expQ.push_back(it);
  endfunction

  task automatic step(input logic w, input logic [31:0] d, input logic op,
                      input logic [4:0] e, input logic ap, input string req);
    logic [4:0] eff;
    logic       t;
    @(negedge clk);
    wrEn = w; wrData = d; opDone = op; opExc = e; opApprox = ap;
    @(posedge clk);
    #1;
    wrEn = 0; opDone = 0; opExc = '0; opApprox = 0;
    t = 1'b0;
    if (w) begin
      model = d & 32'h0005_FFFF;
    end else if (op) begin
      eff = (ap && e == 5'b0) ? 5'b00001 : e;
      model[16:12] = eff;
      model[6:2]   = model[6:2] | eff;
      t = |(eff & model[11:7]);
    end
    pushExp(t, req);
  endtask

  always @(negedge clk) begin
    #1;
    while (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      vectors++;
      if (csrOut !== it.csr || roundToZero !== it.rtz || flushDenorm !== it.fz ||
          trapPulse !== it.trap || trapCode !== it.code) begin
        miscompares++;
        $display("FAIL %s: got csr=%h rtz=%b fz=%b trap=%b code=%h exp csr=%h rtz=%b fz=%b trap=%b code=%h",
                 it.req, csrOut, roundToZero, flushDenorm, trapPulse, trapCode,
                 it.csr, it.rtz, it.fz, it.trap, it.code);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    pushExp(1'b0, "R10 reset");
    // R1 R3 mask with all ones, rounding 11 is nearest (R2)
    step(1, 32'hFFFF_FFFF, 0, 0, 0, "R1 R2 R3 masked write");
    step(1, 32'h0000_0001, 0, 0, 0, "R2 toward-zero");
    step(1, 32'h0000_0002, 0, 0, 0, "R2 encoding 10");
    step(1, 32'h0004_0000, 0, 0, 0, "R3 flush bit");
    step(1, 32'h0000_0000, 0, 0, 0, "R1 clear");
    // R4 R5 successive operations
    step(0, 0, 1, 5'b00100, 0, "R4 R5 overflow");
    step(0, 0, 1, 5'b01000, 0, "R4 R5 divide-by-zero replaces cause");
    step(0, 0, 1, 5'b10001, 0, "R4 R5 invalid+inexact");
    step(0, 0, 1, 5'b00000, 0, "R6 clean op");
    // R8 approximate hint
    step(1, 32'h0000_0000, 0, 0, 0, "R5 write clears flags");
    step(0, 0, 1, 5'b00000, 1, "R8 approx forces inexact");
    step(0, 0, 1, 5'b00100, 1, "R8 approx keeps overflow only");
    // R7 traps: enable divide-by-zero (bit 10)
    step(1, 32'h0000_0400, 0, 0, 0, "R7 enable write");
    step(0, 0, 1, 5'b01000, 0, "R7 enabled cause traps");
    step(0, 0, 0, 0, 0, "R7 trap lasts one cycle");
    step(0, 0, 1, 5'b00001, 0, "R7 disabled cause no trap");
    step(0, 0, 1, 5'b00000, 0, "R6 clean op no trap");
    // R9 write beats a simultaneous trapping op
    step(1, 32'h0000_0401, 1, 5'b01000, 0, "R9 write wins");
    step(0, 0, 0, 0, 0, "R9 no trap after collision");
    // R7 enable all and trap on approx-forced inexact (R8)
    step(1, 32'h0000_0F80, 0, 0, 0, "R7 enable all");
    step(0, 0, 1, 5'b00000, 1, "R7 R8 forced inexact traps");
    step(0, 0, 0, 0, 0, "R7 idle after trap");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule